// File: doc/BRIEF.md
# Copy Engine Interrupt and Watermark Unit

This unit holds the interrupt state for a bank of copy-engine channels. Each channel receives single-cycle pulses for completed copies and for error conditions. It also receives the current fill levels of its source and destination rings. Every channel latches these conditions into a sticky status word. Each condition has its own enable bit, and a channel raises its interrupt line when an enabled status bit is pending.

A summary word collects the pending state of all channels, with one bit per channel. It drives one shared interrupt line, so a handler with a single vector can find which channels need service. Software reads and writes the unit through a plain synchronous register port. A pending status bit is cleared by writing a mask to the channel's status word. The ring fill comparisons use a high and a low threshold per ring, and both thresholds can be programmed.

Top module: `ceirq_unit`

## Requirements
- R1: After reset every enable and status word reads 0, all interrupt outputs are 0, the summary reads 0, and each ring threshold word reads low threshold 0 in bits [15:0] and high threshold RING_ENTRIES in bits [31:16].
- R2: A copy-complete pulse sets status bit 0 at the next clock edge. When host-enable bit 0 is set, the channel interrupt rises one clock after the status bit, and not earlier.
- R3: An error pulse sets status bit 5. Only bit 0 of the separate misc-enable word lets it interrupt, and the host-enable word has no effect on it.
- R4: Status bit 1 sets while source fill is above its high threshold, and bit 2 while it is below its low threshold. Bits 3 and 4 do the same for the destination ring. Host-enable bits 1 to 4 gate these four bits.
- R5: A write to the status word clears exactly the bits that are 1 in the written mask and leaves the other bits unchanged.
- R6: When a condition sets a status bit in the same cycle that a write clears it, the bit stays set.
- R7: Clearing an enable bit drops the interrupt but leaves the status bit pending. Setting the enable again raises the interrupt again.
- R8: The summary word sits at word address NUM_CH*8. Bit c of the summary is 1 when channel c has an enabled pending bit, and it matches irq_ch. irq_any is the OR of the summary bits. Writes to the summary word are ignored.
- R9: Channel c occupies word addresses c*8 to c*8+7, with the host enable at offset 0, misc enable at 1, status at 2, source thresholds at 3 and destination thresholds at 4. Unimplemented bits, offsets 5 to 7 and unmapped addresses read 0. Read data appears one clock after the address.
- R10: A written threshold word reads back unchanged, and later fill comparisons use the new thresholds.
- R11: Channels are independent: an event, an enable or a clear on one channel does not change another channel's status or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| cc_evt | input | NUM_CH | Copy-complete pulse, one bit per channel |
| err_evt | input | NUM_CH | Error pulse, one bit per channel |
| src_occ | input | NUM_CH*CNT_W | Source ring fill level per channel |
| dst_occ | input | NUM_CH*CNT_W | Destination ring fill level per channel |
| irq_ch | output | NUM_CH | Registered per-channel interrupt lines |
| irq_any | output | 1 | Shared interrupt, OR of all channels |

## Verification
The directed tests cover several cases. Single copy-complete pulses check the latency of status, interrupt and summary. An error pulse with every host enable set shows that only the misc enable routes errors. Enable toggles on a pending bit separate masking from clearing. A mixed status word cleared one bit at a time shows that the clear mask is exact. A pulse that lands on the same edge as a clear of the same bit shows which of the two wins. Fill levels on both sides of the default and the reprogrammed thresholds exercise each watermark bit on its own. Events on two channels at once, cleared one at a time, show channel independence and the content of the summary word.

// File: rtl/ceirq_pkg.sv
package ceirq_pkg;
  localparam int WORD_W    = 32;
  localparam int THR_W     = 16;   // threshold field width, high field at [31:16]
  localparam int ST_W      = 6;
  localparam int HEN_W     = 5;
  localparam int CH_STRIDE = 8;

  // status / enable bit positions
  localparam int ST_CC     = 0;
  localparam int ST_SRC_HI = 1;
  localparam int ST_SRC_LO = 2;
  localparam int ST_DST_HI = 3;
  localparam int ST_DST_LO = 4;
  localparam int ST_ERR    = 5;

  typedef enum logic [2:0] {
    OFF_HOST_EN = 3'd0,
    OFF_MISC_EN = 3'd1,
    OFF_STATUS  = 3'd2,
    OFF_SRC_WM  = 3'd3,
    OFF_DST_WM  = 3'd4
  } reg_off_e;
endpackage

// File: rtl/ceirq_wm_cmp.sv
module ceirq_wm_cmp #(
  parameter int CNT_W = 8,
  parameter int THR_W = 16
) (
  input  logic [CNT_W-1:0] occ,
  input  logic [THR_W-1:0] thr_lo,
  input  logic [THR_W-1:0] thr_hi,
  output logic             above,
  output logic             below
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CMP_W-1:0] occ_e, lo_e, hi_e;

  assign occ_e = CMP_W'(occ);
  assign lo_e  = CMP_W'(thr_lo);
  assign hi_e  = CMP_W'(thr_hi);
  assign above = occ_e > hi_e;
  assign below = occ_e < lo_e;
endmodule

// File: rtl/ceirq_chan.sv
module ceirq_chan
  import ceirq_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int RING_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic [2:0]        wr_off,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cc_evt,
  input  logic              err_evt,
  input  logic [CNT_W-1:0]  src_occ,
  input  logic [CNT_W-1:0]  dst_occ,
  output logic [WORD_W-1:0] host_en_word,
  output logic [WORD_W-1:0] misc_en_word,
  output logic [WORD_W-1:0] status_word,
  output logic [WORD_W-1:0] src_wm_word,
  output logic [WORD_W-1:0] dst_wm_word,
  output logic              pend,
  output logic              irq
);
  localparam logic [THR_W-1:0] HI_RST = THR_W'(RING_ENTRIES);

  logic [HEN_W-1:0] host_en_q;
  logic             misc_en_q;
  logic [ST_W-1:0]  status_q;
  logic [THR_W-1:0] src_lo_q, src_hi_q, dst_lo_q, dst_hi_q;
  logic [ST_W-1:0]  set_vec, clr_vec, en_vec;
  logic             src_above, src_below, dst_above, dst_below;
  logic             wr_en_cfg;

  ceirq_wm_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_src_cmp (
    .occ(src_occ), .thr_lo(src_lo_q), .thr_hi(src_hi_q),
    .above(src_above), .below(src_below)
  );

  ceirq_wm_cmp #(.CNT_W(CNT_W), .THR_W(THR_W)) u_dst_cmp (
    .occ(dst_occ), .thr_lo(dst_lo_q), .thr_hi(dst_hi_q),
    .above(dst_above), .below(dst_below)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[ST_CC]     = cc_evt;
    set_vec[ST_SRC_HI] = src_above;
    set_vec[ST_SRC_LO] = src_below;
    set_vec[ST_DST_HI] = dst_above;
    set_vec[ST_DST_LO] = dst_below;
    set_vec[ST_ERR]    = err_evt;
  end

  assign clr_vec = (wr_sel && (wr_off == OFF_STATUS)) ? wr_data[ST_W-1:0] : '0;
  assign en_vec  = {misc_en_q, host_en_q};
  assign pend    = |(status_q & en_vec);

  assign wr_en_cfg = wr_sel && ((wr_off == OFF_HOST_EN) || (wr_off == OFF_MISC_EN) ||
                                (wr_off == OFF_SRC_WM)  || (wr_off == OFF_DST_WM));

  always_ff @(posedge clk) begin
    if (rst) begin
      host_en_q <= '0;
      misc_en_q <= 1'b0;
      status_q  <= '0;
      src_lo_q  <= '0;
      src_hi_q  <= HI_RST;
      dst_lo_q  <= '0;
      dst_hi_q  <= HI_RST;
      irq       <= 1'b0;
    end else begin
      // a set in the same cycle overrides a clear
      status_q <= (status_q & ~clr_vec) | set_vec;
      irq      <= pend;
      if (wr_sel) begin
        case (wr_off)
          OFF_HOST_EN: host_en_q <= wr_data[HEN_W-1:0];
          OFF_MISC_EN: misc_en_q <= wr_data[0];
          OFF_SRC_WM: begin
            src_lo_q <= wr_data[THR_W-1:0];
            src_hi_q <= wr_data[2*THR_W-1:THR_W];
          end
          OFF_DST_WM: begin
            dst_lo_q <= wr_data[THR_W-1:0];
            dst_hi_q <= wr_data[2*THR_W-1:THR_W];
          end
          default: ;
        endcase
      end
    end
  end

  assign host_en_word = WORD_W'(host_en_q);
  assign misc_en_word = WORD_W'(misc_en_q);
  assign status_word  = WORD_W'(status_q);
  assign src_wm_word  = {src_hi_q, src_lo_q};
  assign dst_wm_word  = {dst_hi_q, dst_lo_q};

  // R5: cleared bits without a simultaneous set are gone next cycle
  a_r5_clear_exact: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0) |=> ((status_q & $past(clr_vec) & ~$past(set_vec)) == '0));

  // R6: any set condition is visible next cycle, even against a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

  // R7: writing enables or thresholds never drops a pending status bit
  a_r7_mask_keeps_status: assert property (@(posedge clk) disable iff (rst)
    wr_en_cfg |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R2: the interrupt line follows pending state one cycle later
  a_r2_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (pend && !irq) |=> irq);
endmodule

// File: rtl/ceirq_unit.sv
module ceirq_unit
  import ceirq_pkg::*;
#(
  parameter  int NUM_CH       = 4,
  parameter  int CNT_W        = 8,
  parameter  int RING_ENTRIES = 16,
  localparam int ADDR_W       = $clog2(NUM_CH) + 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_wr_en,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NUM_CH-1:0]       cc_evt,
  input  logic [NUM_CH-1:0]       err_evt,
  input  logic [NUM_CH*CNT_W-1:0] src_occ,
  input  logic [NUM_CH*CNT_W-1:0] dst_occ,
  output logic [NUM_CH-1:0]       irq_ch,
  output logic                    irq_any
);
  localparam int               CIX_W    = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] SUM_ADDR = ADDR_W'(NUM_CH * CH_STRIDE);

  logic [CIX_W-1:0]  addr_cix;
  logic [2:0]        addr_off;
  logic [NUM_CH-1:0] wr_sel, pend_vec, summary_q;
  logic [31:0]       w_host[NUM_CH];
  logic [31:0]       w_misc[NUM_CH];
  logic [31:0]       w_stat[NUM_CH];
  logic [31:0]       w_swm[NUM_CH];
  logic [31:0]       w_dwm[NUM_CH];
  logic [31:0]       rd_next;
  logic              any_q;

  assign addr_cix = reg_addr[ADDR_W-1:3];
  assign addr_off = reg_addr[2:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_sel[g] = reg_wr_en && (addr_cix == CIX_W'(g));

    ceirq_chan #(.CNT_W(CNT_W), .RING_ENTRIES(RING_ENTRIES)) u_chan (
      .clk(clk), .rst(rst),
      .wr_sel(wr_sel[g]), .wr_off(addr_off), .wr_data(reg_wdata),
      .cc_evt(cc_evt[g]), .err_evt(err_evt[g]),
      .src_occ(src_occ[g*CNT_W +: CNT_W]), .dst_occ(dst_occ[g*CNT_W +: CNT_W]),
      .host_en_word(w_host[g]), .misc_en_word(w_misc[g]), .status_word(w_stat[g]),
      .src_wm_word(w_swm[g]), .dst_wm_word(w_dwm[g]),
      .pend(pend_vec[g]), .irq(irq_ch[g])
    );
  end

  always_comb begin
    rd_next = '0;
    if (reg_addr == SUM_ADDR) begin
      rd_next = 32'(summary_q);
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr_cix == CIX_W'(c)) begin
          case (addr_off)
            OFF_HOST_EN: rd_next = w_host[c];
            OFF_MISC_EN: rd_next = w_misc[c];
            OFF_STATUS:  rd_next = w_stat[c];
            OFF_SRC_WM:  rd_next = w_swm[c];
            OFF_DST_WM:  rd_next = w_dwm[c];
            default:     rd_next = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      summary_q <= '0;
      any_q     <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      summary_q <= pend_vec;
      any_q     <= |pend_vec;
    end
  end

  assign irq_any = any_q;

  // R8: summary register and per-channel lines agree
  a_r8_summary_matches_lines: assert property (@(posedge clk) disable iff (rst)
    irq_ch == summary_q);

  // R8: shared line is the OR of the summary
  a_r8_shared_line: assert property (@(posedge clk) disable iff (rst)
    irq_any == (summary_q != '0));
endmodule

// File: tb/ceirq_unit_tb_top.sv
module ceirq_unit_tb_top;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 8;
  localparam int RING   = 16;
  localparam int ADDR_W = $clog2(NUM_CH) + 4;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    reg_wr_en = 1'b0;
  logic [ADDR_W-1:0]       reg_addr = '0;
  logic [31:0]             reg_wdata = '0;
  logic [31:0]             reg_rdata;
  logic [NUM_CH-1:0]       cc_evt = '0;
  logic [NUM_CH-1:0]       err_evt = '0;
  logic [NUM_CH*CNT_W-1:0] src_occ = '0;
  logic [NUM_CH*CNT_W-1:0] dst_occ = '0;
  logic [NUM_CH-1:0]       irq_ch;
  logic                    irq_any;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  ceirq_unit #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .RING_ENTRIES(RING)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cc_evt(cc_evt),
    .err_evt(err_evt), .src_occ(src_occ), .dst_occ(dst_occ),
    .irq_ch(irq_ch), .irq_any(irq_any)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_addr  = ADDR_W'(a);
    reg_wdata = d;
    reg_wr_en = 1'b1;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = ADDR_W'(a);
    step();
    d = reg_rdata;
  endtask

  task automatic pulse_cc(logic [NUM_CH-1:0] m);
    cc_evt = m; step(); cc_evt = '0;
  endtask

  task automatic pulse_err(logic [NUM_CH-1:0] m);
    err_evt = m; step(); err_evt = '0;
  endtask

  task automatic t_reset();
    chk("R1", "irq_ch", 32'(irq_ch), 0);
    chk("R1", "irq_any", 32'(irq_any), 0);
    rd(0, rv);  chk("R1", "host_en ch0", rv, 0);
    rd(2, rv);  chk("R1", "status ch0", rv, 0);
    rd(3, rv);  chk("R1", "src thresholds ch0", rv, 32'h0010_0000);
    rd(28, rv); chk("R1", "dst thresholds ch3", rv, 32'h0010_0000);
    rd(32, rv); chk("R1", "summary", rv, 0);
  endtask

  task automatic t_copy_complete();
    wr(8, 32'h1);
    pulse_cc(4'b0010);
    chk("R2", "irq one cycle after status", 32'(irq_ch), 0);
    step();
    chk("R2", "irq_ch after copy complete", 32'(irq_ch), 32'h2);
    chk("R8", "irq_any", 32'(irq_any), 1);
    rd(10, rv); chk("R2", "status ch1", rv, 32'h1);
    rd(32, rv); chk("R8", "summary", rv, 32'h2);
    wr(10, 32'h1); step();
    chk("R5", "irq after clear", 32'(irq_ch), 0);
    rd(10, rv); chk("R5", "status ch1 after clear", rv, 0);
    wr(8, 32'h0);
  endtask

  task automatic t_error();
    wr(16, 32'h1F);
    pulse_err(4'b0100); step();
    chk("R3", "host enable ignores error", 32'(irq_ch), 0);
    rd(18, rv); chk("R3", "status error bit", rv, 32'h20);
    wr(17, 32'h1); step();
    chk("R3", "misc enable routes error", 32'(irq_ch), 32'h4);
    wr(18, 32'h20); wr(16, 0); wr(17, 0); step();
    chk("R3", "irq after error cleanup", 32'(irq_ch), 0);
  endtask

  task automatic t_mask();
    wr(0, 32'h1);
    pulse_cc(4'b0001); step();
    chk("R7", "irq enabled", 32'(irq_ch), 32'h1);
    wr(0, 32'h0); step();
    chk("R7", "irq masked", 32'(irq_ch), 0);
    rd(2, rv); chk("R7", "status still pending", rv, 32'h1);
    wr(0, 32'h1); step();
    chk("R7", "irq re-enabled", 32'(irq_ch), 32'h1);
    wr(2, 32'h1); wr(0, 32'h0); step();
  endtask

  task automatic t_clear_exact();
    pulse_cc(4'b1000);
    pulse_err(4'b1000);
    rd(26, rv); chk("R5", "mixed status", rv, 32'h21);
    wr(26, 32'h1);
    rd(26, rv); chk("R5", "only masked bit cleared", rv, 32'h20);
    wr(26, 32'hFFFF_FFFF);
    rd(26, rv); chk("R5", "all cleared", rv, 0);
  endtask

  task automatic t_priority();
    reg_addr = ADDR_W'(26); reg_wdata = 32'h1; reg_wr_en = 1'b1; cc_evt = 4'b1000;
    step();
    reg_wr_en = 1'b0; cc_evt = '0;
    rd(26, rv); chk("R6", "set beats clear", rv, 32'h1);
    wr(26, 32'h1);
    rd(26, rv); chk("R6", "later clear works", rv, 0);
  endtask

  task automatic t_watermark();
    src_occ[2*CNT_W +: CNT_W] = 8'd17; step();
    rd(18, rv); chk("R4", "src above default high", rv, 32'h02);
    src_occ[2*CNT_W +: CNT_W] = 8'd8;
    wr(18, 32'hFFFF_FFFF);
    rd(18, rv); chk("R4", "src in range", rv, 0);
    wr(19, {16'd10, 16'd4});
    rd(19, rv); chk("R10", "src threshold readback", rv, 32'h000A_0004);
    src_occ[2*CNT_W +: CNT_W] = 8'd11; step();
    rd(18, rv); chk("R10", "src above new high", rv, 32'h02);
    src_occ[2*CNT_W +: CNT_W] = 8'd3; step();
    wr(18, 32'hFFFF_FFFF); step();
    rd(18, rv); chk("R4", "src below new low", rv, 32'h04);
    src_occ[2*CNT_W +: CNT_W] = 8'd8;
    wr(18, 32'hFFFF_FFFF);
    rd(18, rv); chk("R4", "src back in range", rv, 0);
    wr(20, {16'd5, 16'd2}); step();
    rd(18, rv); chk("R4", "dst below low", rv, 32'h10);
    dst_occ[2*CNT_W +: CNT_W] = 8'd6; step();
    wr(18, 32'hFFFF_FFFF); step();
    rd(18, rv); chk("R4", "dst above high", rv, 32'h08);
    wr(16, 32'h8); step();
    chk("R4", "dst high enable raises irq", 32'(irq_ch), 32'h4);
    dst_occ[2*CNT_W +: CNT_W] = 8'd3;
    wr(16, 0); wr(18, 32'hFFFF_FFFF);
    rd(18, rv); chk("R4", "watermark cleanup", rv, 0);
  endtask

  task automatic t_independent();
    wr(0, 32'h1); wr(24, 32'h1);
    pulse_cc(4'b1001); step();
    chk("R11", "two channels pending", 32'(irq_ch), 32'h9);
    rd(32, rv); chk("R8", "summary two channels", rv, 32'h9);
    wr(2, 32'h1); step();
    chk("R11", "clear ch0 keeps ch3", 32'(irq_ch), 32'h8);
    rd(26, rv); chk("R11", "ch3 status untouched", rv, 32'h1);
    wr(32, 32'h0);
    rd(32, rv); chk("R8", "summary write ignored", rv, 32'h8);
    chk("R8", "irq_any with one channel", 32'(irq_any), 1);
    wr(26, 32'h1); wr(0, 0); wr(24, 0); step();
    chk("R8", "irq_any idle", 32'(irq_any), 0);
  endtask

  task automatic t_regmap();
    wr(8, 32'hFFFF_FFFF);
    rd(8, rv);  chk("R9", "host enable width", rv, 32'h1F);
    wr(9, 32'hFFFF_FFFF);
    rd(9, rv);  chk("R9", "misc enable width", rv, 32'h1);
    rd(13, rv); chk("R9", "offset 5 reads zero", rv, 0);
    rd(40, rv); chk("R9", "unmapped address", rv, 0);
    wr(8, 0); wr(9, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_copy_complete();
    t_error();
    t_mask();
    t_clear_exact();
    t_priority();
    t_watermark();
    t_independent();
    t_regmap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule